// File: doc/BRIEF.md
# Mode-Banked Register File with Exception Entry

This block holds the architectural registers of a 32-bit load-store core that runs in one of several operating modes. Software addresses sixteen logical registers with a 4-bit number. Logical 15 is the program counter. The other fifteen map onto physical storage according to the mode field of the current status word. Some modes therefore see private copies of some registers, while the rest are shared with user mode. Each exception mode also keeps one saved status word.

The file has two read ports and one write port. Both read ports return their data one clock after the index is presented. A separate status write port lets the core update flags or change mode. Exception entry is a single-cycle operation. On one clock edge it stores the old program counter into the link register of the target mode, copies the status word into that mode's saved status, switches the mode, masks interrupts and loads the vector. Exception return restores the program counter and the status word on the same edge.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high, on each clock edge the block sets the program counter to 0, the status word to 0x000000D3 (supervisor mode, I and F set), and every saved status word to 0. Register contents are not reset.
- R2: A read returns, one cycle after the index is presented, the value held before that edge. A write issued in the same cycle is seen only by reads presented in a later cycle (no bypass).
- R3: Status bits [4:0] hold the mode code: user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011. Fast-interrupt mode has private r8–r14.
- R4: The interrupt, supervisor, abort and undefined modes each have a private r13 and r14. Their r0–r12 are the user-mode registers.
- R5: A mode code outside the six listed selects the user registers, and `saved_status` reads 0. `saved_status` also reads 0 in user mode.
- R6: Exception kind codes map to a target mode and a vector as follows: 0 reset → supervisor, 0x00; 1 undefined → undefined, 0x04; 2 software interrupt → supervisor, 0x08; 3 prefetch abort → abort, 0x0C; 4 data abort → abort, 0x10; 5 interrupt → interrupt, 0x18; 6 fast interrupt → fast-interrupt, 0x1C; 7 behaves as code 1.
- R7: On exception entry, a single edge writes the old program counter into r14 of the target mode, writes the old status word into the target mode's saved status, and loads the vector into the program counter.
- R8: The entry status keeps bits [31:8] (N=31, Z=30, C=29, V=28) and takes the target mode code in [4:0]. It sets I (bit 7) and clears T (bit 5). F (bit 6) is set for fast-interrupt entry and kept otherwise.
- R9: When exception entry and a register write fall in the same cycle, the register write is dropped. Entry also takes priority over return and over status writes.
- R10: Return (`ret_en`) loads `ret_addr` into the program counter and, in an exception mode, the saved status into the status word, on the same edge. In user or unlisted modes only the program counter changes. During a return, status writes and writes to logical 15 are ignored.
- R11: A write to logical 15 sets the program counter, and a read of logical 15 returns it. `stat_wr_en` replaces the whole status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_a_data | output | 32 | Read data A, one cycle after index |
| rd_b_data | output | 32 | Read data B, one cycle after index |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| stat_wr_en | input | 1 | Status word write enable |
| stat_wr_data | input | 32 | New status word |
| exc_en | input | 1 | Exception entry strobe |
| exc_kind | input | 3 | Exception kind code (R6) |
| ret_en | input | 1 | Exception return strobe |
| ret_addr | input | 32 | Program counter to restore |
| pc | output | 32 | Program counter |
| status | output | 32 | Current status word |
| saved_status | output | 32 | Saved status of current mode |

## Verification
A wrong bank mapping does not show when the write lands. It shows only when a later read is made in a different mode than the write, so the stimulus keeps switching modes between writes and reads of r8–r14. A bad save on entry shows on `saved_status` in the cycle just after the entry edge. A bad saved link value shows on the first read of r14 in the new mode. A return that restores the wrong word shows in `status` on the next cycle. From that point every read is mapped through the wrong bank, so the errors spread quickly.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int STAT_W   = 32;
  localparam int MODE_W   = 5;
  localparam int KIND_W   = 3;
  localparam int NBANK    = 6;
  localparam int NSAVED   = NBANK - 1;
  localparam int SHARED_N = 8;
  localparam int HI_N     = 5;
  localparam int LINK_BASE = SHARED_N + 2 * HI_N;
  localparam int NPHYS    = LINK_BASE + 2 * NBANK;
  localparam int BIT_I    = 7;
  localparam int BIT_F    = 6;
  localparam int BIT_T    = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  localparam logic [STAT_W-1:0] RESET_STATUS = 32'h0000_00D3;

  typedef enum logic [2:0] {
    BK_USR = 3'd0, BK_FIQ = 3'd1, BK_IRQ = 3'd2,
    BK_SVC = 3'd3, BK_ABT = 3'd4, BK_UND = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BK_FIQ;
      M_IRQ:   return BK_IRQ;
      M_SVC:   return BK_SVC;
      M_ABT:   return BK_ABT;
      M_UND:   return BK_UND;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] entry_mode(input logic [KIND_W-1:0] k);
    case (k)
      3'd0, 3'd2: return M_SVC;
      3'd3, 3'd4: return M_ABT;
      3'd5:       return M_IRQ;
      3'd6:       return M_FIQ;
      default:    return M_UND;
    endcase
  endfunction

  function automatic logic [7:0] entry_vector(input logic [KIND_W-1:0] k);
    case (k)
      3'd0:    return 8'h00;
      3'd2:    return 8'h08;
      3'd3:    return 8'h0C;
      3'd4:    return 8'h10;
      3'd5:    return 8'h18;
      3'd6:    return 8'h1C;
      default: return 8'h04;
    endcase
  endfunction
endpackage

// File: rtl/rf_mode_map.sv
module rf_mode_map
  import rf_pkg::*;
#(
  parameter int LOG_W  = 4,
  parameter int PHYS_W = $clog2(NPHYS)
) (
  input  bank_e             bank,
  input  logic [LOG_W-1:0]  lidx,
  output logic [PHYS_W-1:0] phys
);
  localparam int HI_LO   = SHARED_N;
  localparam int LINK_LO = SHARED_N + HI_N;

  int l_i;
  int b_i;

  always_comb begin
    l_i = int'(lidx);
    b_i = int'(bank);
    if (l_i < HI_LO) begin
      phys = PHYS_W'(l_i);
    end else if (l_i < LINK_LO) begin
      phys = (bank == BK_FIQ) ? PHYS_W'(l_i + HI_N) : PHYS_W'(l_i);
    end else if (l_i < LINK_LO + 2) begin
      phys = PHYS_W'(LINK_BASE + 2 * b_i + (l_i - LINK_LO));
    end else begin
      phys = '0;
    end
  end
endmodule

// File: rtl/rf_bank_mem.sv
module rf_bank_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int NRD    = 2,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_port
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/rf_status_unit.sv
module rf_status_unit
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_en,
  input  logic [KIND_W-1:0] exc_kind,
  input  logic              ret_en,
  input  logic [DATA_W-1:0] ret_addr,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wr_data,
  input  logic              pc_wr_en,
  input  logic [DATA_W-1:0] pc_wr_data,
  output logic [DATA_W-1:0] pc,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] saved
);
  logic [STAT_W-1:0] spsr [NSAVED];
  bank_e             cur_bank;
  bank_e             tgt_bank;
  logic [MODE_W-1:0] tgt_mode;
  logic [2:0]        cur_slot;
  logic [2:0]        tgt_slot;
  logic [STAT_W-1:0] entry_status;

  always_comb begin
    cur_bank = bank_of(status[MODE_W-1:0]);
    tgt_mode = entry_mode(exc_kind);
    tgt_bank = bank_of(tgt_mode);
    cur_slot = 3'(cur_bank) - 3'd1;
    tgt_slot = 3'(tgt_bank) - 3'd1;
    saved    = (cur_bank == BK_USR) ? '0 : spsr[cur_slot];
    entry_status = status;
    entry_status[MODE_W-1:0] = tgt_mode;
    entry_status[BIT_I] = 1'b1;
    entry_status[BIT_F] = status[BIT_F] | (tgt_bank == BK_FIQ);
    entry_status[BIT_T] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      status <= RESET_STATUS;
      for (int i = 0; i < NSAVED; i++) spsr[i] <= '0;
    end else if (exc_en) begin
      spsr[tgt_slot] <= status;
      status         <= entry_status;
      pc             <= DATA_W'(entry_vector(exc_kind));
    end else if (ret_en) begin
      pc <= ret_addr;
      if (cur_bank != BK_USR) status <= saved;
    end else begin
      if (stat_wr_en) status <= stat_wr_data;
      if (pc_wr_en)   pc     <= pc_wr_data;
    end
  end

  // R6: vector follows the kind presented on the entry edge
  assert_vector_R6: assert property (@(posedge clk) disable iff (rst)
    exc_en |=> pc == DATA_W'(entry_vector($past(exc_kind))));

  // R8: entry masks interrupts and leaves the 16-bit stream
  assert_entry_mask_R8: assert property (@(posedge clk) disable iff (rst)
    exc_en |=> (status[BIT_I] && !status[BIT_T] &&
                status[STAT_W-1:8] == $past(status[STAT_W-1:8])));

  // R7: saved status of the new mode holds the old word
  assert_save_R7: assert property (@(posedge clk) disable iff (rst)
    exc_en |=> saved == $past(status));

  // R10: return restores the saved word
  assert_return_R10: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !exc_en && cur_bank != BK_USR) |=> status == $past(saved));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LOG_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LOG_W-1:0]  rd_a_idx,
  input  logic [LOG_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [LOG_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_wr_en,
  input  logic [STAT_W-1:0] stat_wr_data,
  input  logic              exc_en,
  input  logic [KIND_W-1:0] exc_kind,
  input  logic              ret_en,
  input  logic [DATA_W-1:0] ret_addr,
  output logic [DATA_W-1:0] pc,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] saved_status
);
  localparam int NRD    = 2;
  localparam int PHYS_W = $clog2(NPHYS);
  localparam logic [LOG_W-1:0] PC_IDX  = {LOG_W{1'b1}};
  localparam logic [LOG_W-1:0] LNK_IDX = PC_IDX - 1'b1;

  bank_e             cur_bank;
  bank_e             tgt_bank;
  logic [LOG_W-1:0]  rd_idx    [NRD];
  logic [PHYS_W-1:0] rd_phys   [NRD];
  logic [DATA_W-1:0] mem_rdata [NRD];
  logic [DATA_W-1:0] rd_data   [NRD];
  logic [NRD-1:0]    sel_pc_q;
  logic [DATA_W-1:0] pc_q      [NRD];
  logic [PHYS_W-1:0] wr_phys;
  logic [PHYS_W-1:0] lnk_phys;
  logic              mem_we;
  logic [PHYS_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              pc_wr_en;

  assign cur_bank  = bank_of(status[MODE_W-1:0]);
  assign tgt_bank  = bank_of(entry_mode(exc_kind));
  assign rd_idx[0] = rd_a_idx;
  assign rd_idx[1] = rd_b_idx;
  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    rf_mode_map #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_map (
      .bank(cur_bank), .lidx(rd_idx[p]), .phys(rd_phys[p]));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_pc_q[p] <= 1'b0;
        pc_q[p]     <= '0;
      end else begin
        sel_pc_q[p] <= (rd_idx[p] == PC_IDX);
        pc_q[p]     <= pc;
      end
    end

    assign rd_data[p] = sel_pc_q[p] ? pc_q[p] : mem_rdata[p];
  end

  rf_mode_map #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_wmap (
    .bank(cur_bank), .lidx(wr_idx), .phys(wr_phys));

  rf_mode_map #(.LOG_W(LOG_W), .PHYS_W(PHYS_W)) u_lmap (
    .bank(tgt_bank), .lidx(LNK_IDX), .phys(lnk_phys));

  always_comb begin
    pc_wr_en  = wr_en && (wr_idx == PC_IDX);
    mem_we    = exc_en || (wr_en && (wr_idx != PC_IDX));
    mem_waddr = exc_en ? lnk_phys : wr_phys;
    mem_wdata = exc_en ? pc : wr_data;
  end

  rf_bank_mem #(.DATA_W(DATA_W), .DEPTH(NPHYS), .NRD(NRD), .AW(PHYS_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_phys), .rdata(mem_rdata));

  rf_status_unit #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst(rst), .exc_en(exc_en), .exc_kind(exc_kind),
    .ret_en(ret_en), .ret_addr(ret_addr),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(wr_data),
    .pc(pc), .status(status), .saved(saved_status));

  // R5: an entry always lands in a listed exception mode
  assert_mode_R5: assert property (@(posedge clk) disable iff (rst)
    exc_en |=> bank_of(status[MODE_W-1:0]) != BK_USR);

  // R11: a plain write to logical 15 reaches the program counter
  assert_pc_write_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == PC_IDX && !exc_en && !ret_en) |=> pc == $past(wr_data));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, stat_wr_data, ret_addr;
  logic        wr_en, stat_wr_en, exc_en, ret_en;
  logic [2:0]  exc_kind;
  logic [31:0] pc, status, saved_status;

  always #4 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .stat_wr_en(stat_wr_en),
    .stat_wr_data(stat_wr_data), .exc_en(exc_en), .exc_kind(exc_kind),
    .ret_en(ret_en), .ret_addr(ret_addr), .pc(pc), .status(status),
    .saved_status(saved_status));

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;
  string cur_tag  = "R1";

  logic [31:0] m_r [6][15];
  bit          m_v [6][15];
  logic [31:0] m_sp [6];
  logic [31:0] m_pc, m_st;

  function automatic int bk(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int own(input int b, input int l);
    if (l < 8)  return 0;
    if (l < 13) return (b == 1) ? 1 : 0;
    return b;
  endfunction

  function automatic logic [4:0] tmode(input logic [2:0] k);
    case (k)
      3'd0, 3'd2: return 5'h13;
      3'd3, 3'd4: return 5'h17;
      3'd5: return 5'h12;
      3'd6: return 5'h11;
      default: return 5'h1B;
    endcase
  endfunction

  function automatic logic [31:0] tvec(input logic [2:0] k);
    case (k)
      3'd0: return 32'h00;
      3'd2: return 32'h08;
      3'd3: return 32'h0C;
      3'd4: return 32'h10;
      3'd5: return 32'h18;
      3'd6: return 32'h1C;
      default: return 32'h04;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; stat_wr_en = 0; exc_en = 0; ret_en = 0;
    wr_idx = 0; wr_data = 0; stat_wr_data = 0; exc_kind = 0; ret_addr = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] idx, output bit v);
    int b, o;
    if (idx == 4'd15) begin v = 1; return m_pc; end
    b = bk(m_st[4:0]);
    o = own(b, int'(idx));
    v = m_v[o][idx];
    return m_r[o][idx];
  endfunction

  // inputs already driven; predict, clock once, compare
  task automatic step();
    logic [31:0] ea, eb, ost, opc, ns;
    bit va, vb;
    int cb, nb;
    ea = model_read(rd_a_idx, va);
    eb = model_read(rd_b_idx, vb);
    ost = m_st; opc = m_pc; cb = bk(ost[4:0]);
    if (exc_en) begin
      nb = bk(tmode(exc_kind));
      m_r[nb][14] = opc; m_v[nb][14] = 1;
      m_sp[nb] = ost;
      ns = ost;
      ns[4:0] = tmode(exc_kind);
      ns[7] = 1'b1;
      ns[6] = ost[6] | (nb == 1);
      ns[5] = 1'b0;
      m_st = ns;
      m_pc = tvec(exc_kind);
    end else begin
      if (wr_en && wr_idx != 4'd15) begin
        m_r[own(cb, int'(wr_idx))][wr_idx] = wr_data;
        m_v[own(cb, int'(wr_idx))][wr_idx] = 1;
      end
      if (ret_en) begin
        m_pc = ret_addr;
        if (cb != 0) m_st = m_sp[cb];
      end else begin
        if (stat_wr_en) m_st = stat_wr_data;
        if (wr_en && wr_idx == 4'd15) m_pc = wr_data;
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (va) chk("rd_a", rd_a_data, ea);
    if (vb) chk("rd_b", rd_b_data, eb);
    chk("pc", pc, m_pc);
    chk("status", status, m_st);
    chk("saved", saved_status, (bk(m_st[4:0]) == 0) ? 32'h0 : m_sp[bk(m_st[4:0])]);
    idle();
  endtask

  task automatic set_mode(input logic [31:0] w);
    stat_wr_en = 1; stat_wr_data = w; step();
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d, input logic [3:0] ra);
    wr_en = 1; wr_idx = i; wr_data = d; rd_a_idx = ra; rd_b_idx = i; step();
  endtask

  task automatic rd(input logic [3:0] a, input logic [3:0] b);
    rd_a_idx = a; rd_b_idx = b; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [7];
    void'($urandom(32'd20240611));
    modes[0] = 5'h10; modes[1] = 5'h11; modes[2] = 5'h12; modes[3] = 5'h13;
    modes[4] = 5'h17; modes[5] = 5'h1B; modes[6] = 5'h1F;
    for (int b = 0; b < 6; b++) begin
      m_sp[b] = 0;
      for (int l = 0; l < 15; l++) begin m_r[b][l] = 0; m_v[b][l] = 0; end
    end
    m_pc = 0; m_st = 32'h0000_00D3;
    idle(); rd_a_idx = 0; rd_b_idx = 15; rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    cur_tag = "R1";
    chk("pc", pc, 32'h0);
    chk("status", status, 32'h0000_00D3);
    chk("saved", saved_status, 32'h0);
    rst = 0;
    step();

    // R11: logical 15 and status write
    cur_tag = "R11";
    wr(4'd15, 32'h0000_0100, 4'd15);
    rd(4'd15, 4'd15);
    set_mode(32'h0000_0010);

    // R2: user registers, same-cycle read sees old value
    cur_tag = "R2";
    for (int i = 0; i < 15; i++) wr(4'(i), 32'hA000_0000 + 32'(i), 4'(i));
    wr(4'd3, 32'h3333_3333, 4'd3);
    for (int i = 0; i < 15; i++) rd(4'(i), 4'(14 - i));

    // R3: fast-interrupt private r8-r14
    cur_tag = "R3";
    set_mode(32'h0000_00D1);
    for (int i = 8; i < 15; i++) wr(4'(i), 32'hF000_0000 + 32'(i), 4'(i - 8));
    for (int i = 0; i < 15; i++) rd(4'(i), 4'(i));
    set_mode(32'h0000_0010);
    for (int i = 8; i < 15; i++) rd(4'(i), 4'(i));

    // R4: r13/r14 only private in other exception modes
    cur_tag = "R4";
    for (int m = 2; m < 6; m++) begin
      set_mode({27'h0, modes[m]});
      wr(4'd12, 32'hC000_0000 + 32'(m), 4'd8);
      wr(4'd13, 32'hD000_0000 + 32'(m), 4'd13);
      wr(4'd14, 32'hE000_0000 + 32'(m), 4'd14);
    end
    set_mode(32'h0000_0010);
    rd(4'd12, 4'd13); rd(4'd14, 4'd8);

    // R5: unlisted mode maps to user, no saved status
    cur_tag = "R5";
    set_mode(32'h0000_001F);
    rd(4'd13, 4'd14); rd(4'd9, 4'd12);

    // R6/R7/R8: every kind, from a user state with flags and T set
    for (int k = 0; k < 8; k++) begin
      cur_tag = "R8";
      set_mode(32'hF000_0030 | (k[0] ? 32'h40 : 32'h0));
      cur_tag = "R6";
      exc_en = 1; exc_kind = 3'(k); step();
      cur_tag = "R7";
      rd(4'd14, 4'd13);
    end

    // R9: entry beats a same-cycle write
    cur_tag = "R9";
    set_mode(32'h0000_0010);
    exc_en = 1; exc_kind = 3'd5; wr_en = 1; wr_idx = 4'd3; wr_data = 32'hBAD0_0003;
    stat_wr_en = 1; stat_wr_data = 32'h10; step();
    rd(4'd3, 4'd14);

    // R10: return in exception mode and in user mode
    cur_tag = "R10";
    ret_en = 1; ret_addr = 32'h0000_4000; stat_wr_en = 1; stat_wr_data = 32'h13;
    wr_en = 1; wr_idx = 4'd15; wr_data = 32'h0BAD_0000; step();
    ret_en = 1; ret_addr = 32'h0000_5000; step();
    rd(4'd15, 4'd3);

    // R2: random mix across modes
    cur_tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 99));
      rd_a_idx = 4'($urandom_range(0, 15));
      rd_b_idx = 4'($urandom_range(0, 15));
      if (sel < 55) begin
        wr_en = 1; wr_idx = 4'($urandom_range(0, 15)); wr_data = $urandom;
      end
      if (sel >= 55 && sel < 75) begin
        stat_wr_en = 1;
        stat_wr_data = {$urandom} & 32'hFFFF_FFE0 | {27'h0, modes[$urandom_range(0, 6)]};
      end
      if (sel >= 75 && sel < 87) begin
        exc_en = 1; exc_kind = 3'($urandom_range(0, 7));
      end
      if (sel >= 87 && sel < 95) begin
        ret_en = 1; ret_addr = $urandom & 32'hFFFF_FFFC;
      end
      if (sel >= 95) begin
        exc_en = 1; exc_kind = 3'($urandom_range(0, 7));
        wr_en = 1; wr_idx = 4'($urandom_range(0, 14)); wr_data = $urandom;
        ret_en = 1; ret_addr = $urandom;
      end
      step();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule